// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block derives the serial clock timing of an SPI host from its functional clock. It emits a one-cycle strobe each time the serial clock has to change level. Two rate inputs set the spacing of the strobes: an 8-bit linear term `n` and a 2-bit exponent `N`. A full serial period lasts 2*(n+1)*2^N functional cycles, so each half period lasts (n+1)*2^N cycles. The strobe drives the flip-flop that produces the serial clock.

The rate inputs are copied into an internal active setting on every clock edge at which the block is disabled. While it is enabled, the active setting stays frozen. The half-period counter restarts from zero whenever the block is disabled, so the first half period after enabling has full length. The combination n=0, N=0 would divide by two, which is faster than the host allows. That setting is flagged and produces no strobes. A combinational output gives the total divide ratio of the rate inputs as presented, so software or a neighbouring block can read the resulting bit rate.

Top module: `spi_rate_prescaler`

## Requirements
- R1: While enabled with a legal active setting, `sck_toggle` pulses high for exactly one cycle every (n+1)*2^N clock cycles.
- R2: The first pulse after `enable` rises comes after exactly (n+1)*2^N enabled clock edges, including after a disable in the middle of a half period.
- R3: While `enable` is low, `sck_toggle` is low and the next enabled half period restarts from a count of zero.
- R4: Changes on `rate_lin`/`rate_exp` while `enable` is high do not alter the strobe spacing; the active setting is loaded on each clock edge at which `enable` is low.
- R5: The active setting n=0, N=0 raises `cfg_illegal` and produces no pulses on `sck_toggle` while enabled.
- R6: `div_ratio` equals 2*(rate_lin+1)*2^rate_exp combinationally: 4096 for 255/3, and 4 for 1/0 and for 0/1.
- R7: After reset, `sck_toggle` is 0, `cfg_illegal` is 0, and the active setting is the slowest one (n=255, N=3).
- R8: `cfg_illegal` follows the active setting. It changes one clock edge after a new setting is presented with `enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the prescaler; low loads the rate inputs and reloads the counter |
| rate_lin | input | 8 | Linear divisor term n |
| rate_exp | input | 2 | Power-of-two exponent N |
| sck_toggle | output | 1 | One-cycle strobe at each serial clock half-period boundary |
| cfg_illegal | output | 1 | Active setting is the prohibited divide-by-two |
| div_ratio | output | 13 | Total divide ratio 2*(n+1)*2^N of the rate inputs |

## Verification
Every cycle, the assertions check that the counter stays below the active half length. They also check that a strobe is never followed at once by another, that disabling clears the counter and the strobe, that an illegal setting never strobes, and that the active setting cannot move while enabled. They cannot show that the spacing equals exactly (n+1)*2^N or that the first half period has full length. The bench's reference model shows this by counting enabled edges for several settings, including the slowest, a setting changed while running, and a mid-period disable.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  // Half-period length in functional clock cycles: (n + 1) * 2^N
  function automatic int unsigned half_len(input int unsigned lin,
                                           input int unsigned ex);
    return (lin + 1) << ex;
  endfunction

  // Full serial clock divide ratio: 2 * (n + 1) * 2^N
  function automatic int unsigned full_ratio(input int unsigned lin,
                                             input int unsigned ex);
    return half_len(lin, ex) << 1;
  endfunction

endpackage

// File: rtl/presc_cfg_hold.sv
module presc_cfg_hold #(
  parameter int LIN_W    = 8,
  parameter int EXP_W    = 2,
  parameter int HALF_W   = 12,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LIN_W-1:0]  lin_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [HALF_W-1:0] half_q,
  output logic              illegal_q
);
  import spi_presc_pkg::*;

  logic [LIN_W-1:0] lin_q;
  logic [EXP_W-1:0] exp_q;
  logic             load_evt;
  logic             en_seen;

  // Named event: active setting is refreshed on this edge
  assign load_evt = !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '1;
      exp_q <= '1;
    end else if (load_evt) begin
      lin_q <= lin_in;
      exp_q <= exp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else        en_seen <= enable;
  end

  assign half_q    = HALF_W'(half_len(32'(lin_q), 32'(exp_q)));
  assign illegal_q = (half_q < HALF_W'(MIN_HALF));

  // R4: the active setting cannot move while the block keeps running
  a_r4_hold_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_seen) |-> ($stable(lin_q) && $stable(exp_q)));

endmodule

// File: rtl/presc_half_counter.sv
module presc_half_counter #(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              illegal,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic              run;
  logic              wrap_hit;

  assign run      = enable && !illegal;
  assign wrap_hit = (cnt == half_len - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap_hit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + HALF_W'(1);
      tick <= 1'b0;
    end
  end

  // R1: count never reaches the half length
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_len));

  // R1: strobes are single-cycle, never back to back
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3: disabling reloads the counter and silences the strobe
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0 && !tick));

endmodule

// File: rtl/spi_rate_prescaler.sv
module spi_rate_prescaler #(
  parameter int LIN_W    = 8,
  parameter int EXP_W    = 2,
  parameter int MIN_HALF = 2,
  localparam int HALF_W  = LIN_W + (1 << EXP_W),
  localparam int RATIO_W = HALF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LIN_W-1:0]   rate_lin,
  input  logic [EXP_W-1:0]   rate_exp,
  output logic               sck_toggle,
  output logic               cfg_illegal,
  output logic [RATIO_W-1:0] div_ratio
);
  import spi_presc_pkg::*;

  logic [HALF_W-1:0] active_half;

  presc_cfg_hold #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W), .MIN_HALF(MIN_HALF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .lin_in(rate_lin), .exp_in(rate_exp),
    .half_q(active_half), .illegal_q(cfg_illegal)
  );

  presc_half_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .illegal(cfg_illegal), .half_len(active_half),
    .tick(sck_toggle)
  );

  assign div_ratio = RATIO_W'(full_ratio(32'(rate_lin), 32'(rate_exp)));

  // R5: a prohibited setting never strobes
  a_r5_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> !sck_toggle);

endmodule

// File: tb/spi_rate_prescaler_tb.sv
module spi_rate_prescaler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  rate_lin = 8'd0;
  logic [1:0]  rate_exp = 2'd0;
  logic        sck_toggle;
  logic        cfg_illegal;
  logic [12:0] div_ratio;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R7";

  // reference model state
  int m_n = 255, m_e = 3, m_run = 0, m_tick = 0, m_ill = 0;

  spi_rate_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rate_lin(rate_lin), .rate_exp(rate_exp),
    .sck_toggle(sck_toggle), .cfg_illegal(cfg_illegal),
    .div_ratio(div_ratio)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // behavioural reference: counts enabled edges since enable
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_n = 255; m_e = 3; m_run = 0; m_tick = 0;
    end else if (!enable) begin
      m_n = rate_lin; m_e = rate_exp; m_run = 0; m_tick = 0;
    end else if (m_n == 0 && m_e == 0) begin
      m_tick = 0;
    end else begin
      m_run++;
      m_tick = (m_run % ((m_n + 1) * (2 ** m_e)) == 0) ? 1 : 0;
    end
    m_ill = (m_n == 0 && m_e == 0) ? 1 : 0;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(tag, "sck_toggle", sck_toggle, m_tick);
      chk(tag, "cfg_illegal", cfg_illegal, m_ill);
      chk("R6", "div_ratio", div_ratio, 2 * (rate_lin + 1) * (2 ** rate_exp));
    end
  end

  task automatic run_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_rate(input int n, input int e);
    rate_lin = 8'(n); rate_exp = 2'(e);
  endtask

  task automatic count_ticks(input int k, output int nt);
    nt = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (sck_toggle) nt++;
    end
  endtask

  initial begin
    int nt;
    run_cycles(3);
    chk("R7", "reset sck_toggle", sck_toggle, 0);
    chk("R7", "reset cfg_illegal", cfg_illegal, 0);
    rst_n = 1'b1;
    // R7: slowest active setting right after reset: no strobe within 2047 edges
    tag = "R7"; enable = 1'b1;
    count_ticks(2047, nt);
    chk("R7", "ticks before first slowest half period", nt, 0);
    run_cycles(1);
    chk("R7", "first tick at 2048", sck_toggle, 1);
    enable = 1'b0; run_cycles(2);

    // R1/R2: fastest legal half length 2
    tag = "R1"; set_rate(1, 0); run_cycles(2);
    chk("R6", "ratio 1/0", div_ratio, 4);
    enable = 1'b1;
    count_ticks(20, nt);
    chk("R1", "ticks in 20 cycles at half=2", nt, 10);

    // R2: disable mid-period, re-enable with half length 6
    tag = "R2"; enable = 1'b0; set_rate(2, 1); run_cycles(3);
    enable = 1'b1;
    count_ticks(5, nt);
    chk("R2", "no tick before 6th edge", nt, 0);
    run_cycles(1);
    chk("R2", "tick at 6th enabled edge", sck_toggle, 1);
    run_cycles(3);
    tag = "R3"; enable = 1'b0;
    count_ticks(5, nt);
    chk("R3", "no ticks while disabled", nt, 0);
    tag = "R2"; enable = 1'b1;
    count_ticks(5, nt);
    chk("R2", "full half period after mid-period disable", nt, 0);
    run_cycles(1);
    chk("R2", "tick on 6th edge after re-enable", sck_toggle, 1);

    // R4: inputs change while running, spacing stays at 6
    tag = "R4"; set_rate(0, 0); run_cycles(3); set_rate(7, 2);
    count_ticks(36, nt);
    chk("R4", "spacing held at half=6", nt, 6);
    chk("R6", "ratio 7/2 live", div_ratio, 64);

    // R5/R8: prohibited setting
    tag = "R8"; enable = 1'b0; set_rate(0, 0);
    chk("R8", "flag not yet updated", cfg_illegal, 0);
    run_cycles(1);
    chk("R8", "flag after load edge", cfg_illegal, 1);
    chk("R6", "ratio 0/0", div_ratio, 2);
    tag = "R5"; enable = 1'b1;
    count_ticks(30, nt);
    chk("R5", "no ticks for illegal setting", nt, 0);
    tag = "R8"; enable = 1'b0; set_rate(0, 1); run_cycles(1);
    chk("R8", "flag clears for 0/1", cfg_illegal, 0);
    chk("R6", "ratio 0/1", div_ratio, 4);
    tag = "R1"; enable = 1'b1;
    count_ticks(20, nt);
    chk("R1", "ticks at 0/1", nt, 10);

    // R1/R6: slowest setting, two half periods
    enable = 1'b0; set_rate(255, 3); run_cycles(1);
    chk("R6", "ratio 255/3", div_ratio, 4096);
    enable = 1'b1;
    count_ticks(4096, nt);
    chk("R1", "ticks over 4096 cycles at slowest", nt, 2);
    enable = 1'b0; run_cycles(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule